// File: doc/BRIEF.md
# Shift Register with Set/Clear/Toggle Serial Entry

A clocked register of `WIDTH` bits (four by default) with two working modes chosen by an active-low load select. While the load select is low, every bit of the register takes the matching bit of a parallel data word on the rising clock edge. While it is high, the register moves its contents one place toward the top bit on each rising edge, and bit 0 takes a new value from a pair of control inputs.

The control pair for the entry stage is an active-high `set_j` and an active-low `keep_kn`. Together they choose one of four actions for bit 0: clear it, keep it, invert it, or set it. When the two pins are tied together, the pair works as a plain serial data input. An active-low asynchronous clear empties the register at once and takes priority over every other input. A separate output always shows the inverse of the top bit.

Top module: `jk_shift_reg`

## Requirements
- R1: When `load_n` is 0 at a rising clock edge (and `clr_n` is 1), `q[i]` becomes `par[i]` for every bit i, and `set_j`/`keep_kn` have no effect.
- R2: When `load_n` is 1 at a rising clock edge, `q[i]` becomes the old `q[i-1]` for each i from 1 to WIDTH-1, so data moves from bit 0 toward bit WIDTH-1.
- R3: In shift mode with `set_j`=0 and `keep_kn`=0, the new `q[0]` is 0.
- R4: In shift mode with `set_j`=0 and `keep_kn`=1, `q[0]` keeps its old value.
- R5: In shift mode with `set_j`=1 and `keep_kn`=0, the new `q[0]` is the inverse of the old `q[0]`.
- R6: In shift mode with `set_j`=1 and `keep_kn`=1, the new `q[0]` is 1.
- R7: While `clr_n` is 0, `q` is all zeros. The clear takes effect without a clock edge, and edges that arrive during the clear have no effect.
- R8: `q_last_n` always equals the inverse of `q[WIDTH-1]`, and is 1 after a clear.
- R9: The first rising edge after `clr_n` returns to 1 performs a normal load or shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all transfers happen on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | 0 = parallel load, 1 = shift toward the top bit |
| set_j | input | 1 | Entry-stage control, active high |
| keep_kn | input | 1 | Entry-stage control, active low |
| par | input | WIDTH | Parallel data word |
| q | output | WIDTH | Register contents |
| q_last_n | output | 1 | Inverse of the top bit |

## Verification
A wrong entry action shows on `q[0]` one edge after the shift. It then walks up the register and reaches `q_last_n` WIDTH-1 edges later. A wrong mode select or a broken stage link shows on `q` right after the edge where it occurs, because every bit is a plain output flop. The bench sweeps every starting value through every entry action and through a load. After each edge it compares `q` and `q_last_n` with an arithmetic model, so any such fault is caught within one cycle. The clear is checked part-way through a clock period, before any edge could mask it.

// File: rtl/jksr_pkg.sv
package jksr_pkg;

  typedef enum logic [1:0] {
    ENT_CLEAR  = 2'b00,
    ENT_KEEP   = 2'b01,
    ENT_INVERT = 2'b10,
    ENT_SET    = 2'b11
  } entry_act_t;

  function automatic entry_act_t decode_entry(input logic j, input logic kn);
    return entry_act_t'({j, kn});
  endfunction

endpackage

// File: rtl/jksr_entry.sv
module jksr_entry
  import jksr_pkg::*;
(
  input  logic j,
  input  logic kn,
  input  logic cur,
  output logic nxt
);
  entry_act_t act;

  always_comb begin
    act = decode_entry(j, kn);
    unique case (act)
      ENT_CLEAR:  nxt = 1'b0;
      ENT_KEEP:   nxt = cur;
      ENT_INVERT: nxt = ~cur;
      ENT_SET:    nxt = 1'b1;
      default:    nxt = 1'b0;
    endcase
  end
endmodule

// File: rtl/jksr_cell.sv
module jksr_cell (
  input  logic clk,
  input  logic clr_n,
  input  logic load_n,
  input  logic shift_in,
  input  logic par_in,
  output logic q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= 1'b0;
    else        q <= load_n ? shift_in : par_in;
  end

  AST_CELL_LOAD: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(par_in)); // R1
endmodule

// File: rtl/jk_shift_reg.sv
module jk_shift_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             set_j,
  input  logic             keep_kn,
  input  logic [WIDTH-1:0] par,
  output logic [WIDTH-1:0] q,
  output logic             q_last_n
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] shift_src;
  logic             entry_nxt;

  jksr_entry u_entry (
    .j   (set_j),
    .kn  (keep_kn),
    .cur (q[0]),
    .nxt (entry_nxt)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign shift_src[i] = entry_nxt;
    end else begin : g_body
      assign shift_src[i] = q[i-1];
      AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!clr_n)
        load_n |=> q[i] == $past(q[i-1])); // R2
    end
    jksr_cell u_cell (
      .clk      (clk),
      .clr_n    (clr_n),
      .load_n   (load_n),
      .shift_in (shift_src[i]),
      .par_in   (par[i]),
      .q        (q[i])
    );
  end

  assign q_last_n = ~q[TOP];

  AST_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !set_j && !keep_kn) |=> !q[0]); // R3
  AST_ENTRY_KEEP: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !set_j && keep_kn) |=> $stable(q[0])); // R4
  AST_ENTRY_INVERT: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && set_j && !keep_kn) |=> q[0] != $past(q[0])); // R5
  AST_ENTRY_SET: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && set_j && keep_kn) |=> q[0]); // R6
  AST_CLEAR_HOLDS: assert property (@(posedge clk)
    !clr_n |-> q == '0); // R7
endmodule

// File: tb/jk_shift_reg_tb.sv
module jk_shift_reg_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic         load_n = 1'b1;
  logic         set_j = 1'b0;
  logic         keep_kn = 1'b0;
  logic [W-1:0] par = '0;
  logic [W-1:0] q;
  logic         q_last_n;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] model = '0;

  always #5 clk = ~clk;

  jk_shift_reg #(.WIDTH(W)) u_dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .set_j(set_j),
    .keep_kn(keep_kn), .par(par), .q(q), .q_last_n(q_last_n)
  );

  task automatic check(input string req, input logic [W-1:0] exp);
    checks++;
    if (q !== exp || q_last_n !== ~exp[W-1]) begin
      fails++;
      $display("FAIL %s q=%h q_last_n=%b expected q=%h q_last_n=%b",
               req, q, q_last_n, exp, ~exp[W-1]);
    end
  endtask

  function automatic logic [W-1:0] next_val(input logic [W-1:0] cur,
      input logic ld_n, input logic j, input logic kn, input logic [W-1:0] p);
    logic b0;
    if (!ld_n) return p;
    case ({j, kn})
      2'b00: b0 = 1'b0;
      2'b01: b0 = cur[0];
      2'b10: b0 = ~cur[0];
      default: b0 = 1'b1;
    endcase
    return {cur[W-2:0], b0};
  endfunction

  task automatic step(input string req, input logic ld_n, input logic j,
                      input logic kn, input logic [W-1:0] p);
    @(negedge clk);
    load_n = ld_n; set_j = j; keep_kn = kn; par = p;
    model = next_val(model, ld_n, j, kn, p);
    @(posedge clk);
    #1;
    check(req, model);
  endtask

  initial begin
    #2 check("R7 reset state", '0);
    repeat (2) @(posedge clk);
    #3 clr_n = 1'b1;
    // R1/R2/R3..R6 sweep: every start value, every entry action, plus loads
    for (int v = 0; v < (1 << W); v++) begin
      for (int a = 0; a < 4; a++) begin
        step("R1 load", 1'b0, a[1], a[0], v[W-1:0]);
        case (a)
          0: step("R3 R2 clear entry",  1'b1, 1'b0, 1'b0, ~v[W-1:0]);
          1: step("R4 R2 keep entry",   1'b1, 1'b0, 1'b1, ~v[W-1:0]);
          2: step("R5 R2 invert entry", 1'b1, 1'b1, 1'b0, ~v[W-1:0]);
          default: step("R6 R2 set entry", 1'b1, 1'b1, 1'b1, ~v[W-1:0]);
        endcase
      end
    end
    // R8: walk a one through the top bit by serial D-style entry
    step("R8 load zero", 1'b0, 1'b0, 1'b0, '0);
    step("R8 enter one", 1'b1, 1'b1, 1'b1, '0);
    for (int k = 0; k < W; k++) step("R8 walk", 1'b1, 1'b0, 1'b0, '1);
    // R7: clear in the middle of a period, then edges during clear
    step("R7 preload", 1'b0, 1'b0, 1'b0, '1);
    @(negedge clk);
    #1 clr_n = 1'b0;
    #1 check("R7 async clear mid-period", '0);
    load_n = 1'b0; par = 4'hA;
    @(posedge clk); #1 check("R7 edge ignored during clear", '0);
    @(posedge clk); #3 clr_n = 1'b1;
    model = '0;
    #1 check("R7 still clear after release", '0);
    step("R9 first edge loads", 1'b0, 1'b0, 1'b0, 4'h9);
    // R9: first edge after a release shifts normally
    @(negedge clk); clr_n = 1'b0;
    @(posedge clk); #3 clr_n = 1'b1; model = '0;
    step("R9 first edge shifts", 1'b1, 1'b1, 1'b0, '0);
    step("R5 invert again", 1'b1, 1'b1, 1'b0, '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    checks++;
    $display("FAIL watchdog expired q=%h expected run end", q);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule